// File: doc/BRIEF.md
# Memory Type Range Register File

This block holds the configuration that assigns memory types to physical address ranges. It contains one default-type register, eleven fixed-range registers, a parameterised number of variable base/mask pairs and a read-only capability register. Software reaches them over a single-cycle register bus: an index, 64-bit write data, a write strobe and a combinational read-data path. A write is committed at the rising clock edge.

Each write is checked for legality before it is committed. The checks cover the type codes in every type field and the reserved bits, some of which depend on the physical address width. A write that fails is flagged with an error in the same cycle and leaves all state untouched. The stored configuration is driven out as flat vectors for a lookup unit further down the pipeline.

Register indices: 0x00 capability, 0x01 default type, 0x10 to 0x1A fixed-range registers, and 0x20 upward the variable pairs. An even index is a base and an odd index is a mask, and pair p sits at 0x20+2p and 0x21+2p.

Top module: `memtype_range_bank`

## Requirements
- R1: After reset every stored register and every export is zero. Index 0x00 reads 0x500 ORed with PAIRS at all times.
- R2: The legal type codes are 0, 1, 4, 5 and 6. A write to index 0x01 is accepted only if its type (bits 7:0) is legal and no bit other than 11, 10 and 7:0 is set. Bit 11 drives glb_en, bit 10 drives fix_en and bits 7:0 drive dflt_type. The register reads back as written.
- R3: A write to a fixed-range register (0x10 to 0x1A) is accepted only if all eight byte fields hold legal type codes. Register k is exported at fixed_flat[64k+63:64k].
- R4: A base write is accepted only if its type (bits 7:0) is legal and bits 11:8 and every bit at or above PA_BITS are zero.
- R5: A mask write is accepted only if bits 10:0 and every bit at or above PA_BITS are zero. It is stored and exported with every bit at or above PA_BITS set to one. Bit 11 of the mask drives pair_valid.
- R6: Reading a base or mask returns the stored value with every bit at or above PA_BITS cleared.
- R7: A rejected write raises err in its own cycle and changes no stored state or export.
- R8: An unmapped index, or a write to index 0x00, raises err and changes no state. An unmapped index reads as zero.
- R9: Read data in the cycle of a write shows the value from before that write. The new value is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx | input | 8 | Register index |
| wdata | input | 64 | Write data |
| wr | input | 1 | Write strobe |
| rdata | output | 64 | Read data for idx (combinational) |
| err | output | 1 | Unmapped index, or a rejected write |
| glb_en | output | 1 | Global enable |
| fix_en | output | 1 | Fixed-range enable |
| dflt_type | output | 8 | Default memory type |
| fixed_flat | output | 704 | Eleven fixed-range registers, register k at bits 64k+63:64k |
| base_flat | output | 64*PAIRS | Variable bases, pair p at bits 64p+63:64p |
| mask_flat | output | 64*PAIRS | Variable masks as stored, implicit high ones included |
| pair_valid | output | PAIRS | Valid bit of each pair |

## Verification
The read path and the write path act in the same cycle whenever the strobe is raised. In that cycle rdata must still show the old contents while err reports the verdict on the new data. The bench samples both just before the edge that commits the write, and then reads the same index again one cycle later. Rejected writes are followed by a full comparison of every export against the reference model, so that a partial commit cannot go unseen.

// File: rtl/memtype_range_bank.sv
module memtype_range_bank #(
  parameter int PAIRS   = 8,
  parameter int PA_BITS = 36
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            idx,
  input  logic [63:0]           wdata,
  input  logic                  wr,
  output logic [63:0]           rdata,
  output logic                  err,
  output logic                  glb_en,
  output logic                  fix_en,
  output logic [7:0]            dflt_type,
  output logic [11*64-1:0]      fixed_flat,
  output logic [PAIRS*64-1:0]   base_flat,
  output logic [PAIRS*64-1:0]   mask_flat,
  output logic [PAIRS-1:0]      pair_valid
);
  localparam int          PW        = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int          VAR_FIRST = 32;
  localparam logic [63:0] HI        = ~64'd0 << PA_BITS;
  localparam logic [63:0] CAP       = 64'h500 | 64'(PAIRS);

  logic [63:0] deft;
  logic [63:0] fixr  [0:10];
  logic [63:0] vbase [0:PAIRS-1];
  logic [63:0] vmask [0:PAIRS-1];

  logic          is_cap, is_def, is_fix, is_var, fix_ok, legal, we;
  logic [PW-1:0] pair_i;

  function automatic logic ok_t(input logic [7:0] t);
    return t inside {8'd0, 8'd1, 8'd4, 8'd5, 8'd6};
  endfunction

  assign is_cap = (idx == 8'h00);
  assign is_def = (idx == 8'h01);
  assign is_fix = (idx[7:4] == 4'h1) && (idx[3:0] <= 4'd10);

  always_comb begin
    is_var = 1'b0;
    pair_i = '0;
    for (int p = 0; p < PAIRS; p++) begin
      if (idx[7:1] == 7'((VAR_FIRST + 2*p) >> 1)) begin
        is_var = 1'b1;
        pair_i = PW'(p);
      end
    end
  end

  always_comb begin
    fix_ok = 1'b1;
    for (int b = 0; b < 8; b++) fix_ok = fix_ok & ok_t(wdata[b*8 +: 8]);
    legal = 1'b0;
    if (is_def)
      legal = ((wdata & ~64'hCFF) == 64'd0) && ok_t(wdata[7:0]);
    else if (is_fix)
      legal = fix_ok;
    else if (is_var && idx[0])
      legal = ((wdata & (HI | 64'h7FF)) == 64'd0);
    else if (is_var)
      legal = ok_t(wdata[7:0]) && ((wdata & (HI | 64'hF00)) == 64'd0);
  end

  assign we  = wr && legal;
  assign err = !(is_cap || is_def || is_fix || is_var) || (wr && !legal);

  always_comb begin
    rdata = '0;
    if (is_cap)      rdata = CAP;
    else if (is_def) rdata = deft;
    else if (is_fix) rdata = fixr[idx[3:0]];
    else if (is_var) rdata = (idx[0] ? vmask[pair_i] : vbase[pair_i]) & ~HI;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deft <= '0;
      for (int k = 0; k < 11; k++) fixr[k] <= '0;
      for (int p = 0; p < PAIRS; p++) begin
        vbase[p] <= '0;
        vmask[p] <= '0;
      end
    end else if (we) begin
      if (is_def)              deft <= wdata;
      else if (is_fix)         fixr[idx[3:0]] <= wdata;
      else if (idx[0])         vmask[pair_i] <= wdata | HI;
      else                     vbase[pair_i] <= wdata;
    end
  end

  assign glb_en    = deft[11];
  assign fix_en    = deft[10];
  assign dflt_type = deft[7:0];

  genvar g;
  generate
    for (g = 0; g < 11; g++) begin : g_fix
      assign fixed_flat[g*64 +: 64] = fixr[g];
    end
    for (g = 0; g < PAIRS; g++) begin : g_var
      assign base_flat[g*64 +: 64] = vbase[g];
      assign mask_flat[g*64 +: 64] = vmask[g];
      assign pair_valid[g]         = vmask[g][11];
    end
  endgenerate
endmodule

module memtype_range_bank_chk #(
  parameter int PAIRS   = 8,
  parameter int PA_BITS = 36
) (
  input logic                clk,
  input logic                rst_n,
  input logic [7:0]          idx,
  input logic                wr,
  input logic [63:0]         rdata,
  input logic                err,
  input logic                glb_en,
  input logic                fix_en,
  input logic [7:0]          dflt_type,
  input logic [11*64-1:0]    fixed_flat,
  input logic [PAIRS*64-1:0] base_flat,
  input logic [PAIRS*64-1:0] mask_flat,
  input logic [PAIRS-1:0]    pair_valid
);
  localparam logic [63:0] HI  = ~64'd0 << PA_BITS;
  localparam logic [63:0] CAP = 64'h500 | 64'(PAIRS);

  a_r1_cap_value: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == 8'h00) |-> (rdata == CAP));

  a_r7_reject_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && err) |=> ($stable(glb_en) && $stable(fix_en) && $stable(dflt_type) &&
                     $stable(fixed_flat) && $stable(base_flat) && $stable(mask_flat)));

  a_r8_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !wr) |-> (rdata == 64'd0));

  a_r6_readback_stripped: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(idx) >= 32) && (int'(idx) < 32 + 2*PAIRS)) |-> ((rdata & HI) == 64'd0));

  genvar g;
  generate
    for (g = 0; g < PAIRS; g++) begin : g_pv
      a_r5_valid_has_high_ones: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid[g] |-> ((mask_flat[g*64 +: 64] & HI) == HI));
    end
  endgenerate
endmodule

bind memtype_range_bank memtype_range_bank_chk #(.PAIRS(PAIRS), .PA_BITS(PA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .idx(idx), .wr(wr), .rdata(rdata), .err(err),
  .glb_en(glb_en), .fix_en(fix_en), .dflt_type(dflt_type), .fixed_flat(fixed_flat),
  .base_flat(base_flat), .mask_flat(mask_flat), .pair_valid(pair_valid)
);

// File: tb/memtype_range_bank_tb.sv
`timescale 1ns/1ps
module memtype_range_bank_tb;
  localparam int N  = 8;
  localparam int PA = 36;
  localparam logic [63:0] HI = ~64'd0 << PA;

  logic clk = 0, rst_n = 0, wr = 0;
  logic [7:0] idx = 0;
  logic [63:0] wdata = 0, rdata;
  logic err, glb_en, fix_en;
  logic [7:0] dflt_type;
  logic [11*64-1:0] fixed_flat;
  logic [N*64-1:0] base_flat, mask_flat;
  logic [N-1:0] pair_valid;

  always #2.5 clk = ~clk;

  memtype_range_bank #(.PAIRS(N), .PA_BITS(PA)) u_dut (
    .clk(clk), .rst_n(rst_n), .idx(idx), .wdata(wdata), .wr(wr), .rdata(rdata), .err(err),
    .glb_en(glb_en), .fix_en(fix_en), .dflt_type(dflt_type), .fixed_flat(fixed_flat),
    .base_flat(base_flat), .mask_flat(mask_flat), .pair_valid(pair_valid));

  int checks = 0, failures = 0;
  logic [63:0] m_def;
  logic [63:0] m_fix [11];
  logic [63:0] m_base [N];
  logic [63:0] m_mask [N];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit code_ok(input logic [7:0] t);
    case (t)
      8'd0, 8'd1, 8'd4, 8'd5, 8'd6: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int kind(input logic [7:0] i);
    if (i == 0) return 0;
    if (i == 1) return 1;
    if (i >= 8'h10 && i <= 8'h1A) return 2;
    if (i >= 8'h20 && i < 8'h20 + 2*N) return (i % 2 == 0) ? 3 : 4;
    return 5;
  endfunction

  function automatic bit legal(input logic [7:0] i, input logic [63:0] d);
    bit ok;
    case (kind(i))
      1: return (d[63:12] == 0) && (d[9:8] == 0) && code_ok(d[7:0]);
      2: begin
        ok = 1;
        for (int b = 0; b < 8; b++) if (!code_ok(d[b*8 +: 8])) ok = 0;
        return ok;
      end
      3: return code_ok(d[7:0]) && (d[11:8] == 0) && ((d & HI) == 0);
      4: return (d[10:0] == 0) && ((d & HI) == 0);
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] exp_rd(input logic [7:0] i);
    case (kind(i))
      0: return 64'h500 + 64'(N);
      1: return m_def;
      2: return m_fix[i - 8'h10];
      3: return m_base[(i - 8'h20) / 2] & ~HI;
      4: return m_mask[(i - 8'h20) / 2] & ~HI;
      default: return 0;
    endcase
  endfunction

  task automatic cmp_exports(input string tag);
    logic [11*64-1:0] ef;
    logic [N*64-1:0] eb, em;
    logic [N-1:0] ev;
    for (int k = 0; k < 11; k++) ef[k*64 +: 64] = m_fix[k];
    for (int p = 0; p < N; p++) begin
      eb[p*64 +: 64] = m_base[p];
      em[p*64 +: 64] = m_mask[p];
      ev[p] = m_mask[p][11];
    end
    check(glb_en == m_def[11] && fix_en == m_def[10] && dflt_type == m_def[7:0],
          {tag, " def exports"}, {53'd0, glb_en, fix_en, 1'b0, dflt_type}, {53'd0, m_def[11:10], 1'b0, m_def[7:0]});
    check(fixed_flat == ef && base_flat == eb, {tag, " fixed/base exports"}, base_flat[63:0], eb[63:0]);
    check(mask_flat == em && pair_valid == ev, {tag, " mask exports"}, mask_flat[63:0], em[63:0]);
  endtask

  task automatic op(input logic [7:0] i, input logic [63:0] d, input bit w, input string tag);
    bit lg, e_err;
    logic [63:0] e_rd;
    @(negedge clk);
    idx = i; wdata = d; wr = w;
    #1;
    lg = legal(i, d);
    e_err = (kind(i) == 5) || (w && !lg);
    e_rd = exp_rd(i);
    check(err == e_err, {tag, " err"}, {63'd0, err}, {63'd0, e_err});
    check(rdata == e_rd, {tag, " rdata"}, rdata, e_rd);
    @(posedge clk);
    #0.5;
    if (w && lg) begin
      case (kind(i))
        1: m_def = d;
        2: m_fix[i - 8'h10] = d;
        3: m_base[(i - 8'h20) / 2] = d;
        4: m_mask[(i - 8'h20) / 2] = d | HI;
        default: ;
      endcase
    end
    wr = 0;
    cmp_exports(tag);
  endtask

  initial begin
    #1000000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_def = 0;
    for (int k = 0; k < 11; k++) m_fix[k] = 0;
    for (int p = 0; p < N; p++) begin m_base[p] = 0; m_mask[p] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    op(8'h00, 0, 0, "R1 cap read");
    op(8'h01, 0, 0, "R1 def after reset");
    op(8'h1A, 0, 0, "R1 fixed after reset");
    op(8'h21, 0, 0, "R1 mask after reset");

    op(8'h01, 64'hC06, 1, "R2 def legal");
    op(8'h01, 0, 0, "R2 def readback");
    op(8'h01, 64'h1006, 1, "R7 def reserved bit");
    op(8'h01, 64'h402, 1, "R2 def type 2");
    op(8'h01, 64'h803, 1, "R2 def type 3");
    op(8'h01, 64'h408, 1, "R2 def type 8");
    op(8'h01, 64'h401, 1, "R9 write new def");
    op(8'h01, 0, 0, "R9 def next cycle");

    op(8'h13, 64'h0605040100060504, 1, "R3 fixed legal");
    op(8'h13, 0, 0, "R3 fixed readback");
    op(8'h13, 64'h0605040100070504, 1, "R3 fixed byte2 code7");
    op(8'h10, 64'h8000000000000000, 1, "R3 fixed top byte 0x80");
    op(8'h1A, 64'h0101010101010101, 1, "R3 last fixed legal");

    op(8'h20, 64'h0000000123450006, 1, "R4 base legal");
    op(8'h20, 0, 0, "R6 base readback");
    op(8'h20, 64'h0000001000000006, 1, "R4 base bit at PA");
    op(8'h20, 64'h0000000000000206, 1, "R4 base bit 9");
    op(8'h20, 64'h0000000000000007, 1, "R4 base type 7");

    op(8'h21, 64'h0000000FFFF00800, 1, "R5 mask legal");
    op(8'h21, 0, 0, "R6 mask readback stripped");
    op(8'h21, 64'h0000000FFFF00808, 1, "R5 mask low bit");
    op(8'h21, 64'h0000010000000800, 1, "R5 mask bit 40");
    op(8'h2F, 64'h0000000000000800, 1, "R5 last pair mask");
    op(8'h2E, 64'h0000000FFFFFF004, 1, "R4 last pair base");
    op(8'h2F, 64'h0000000000000000, 1, "R5 clear valid");

    op(8'h30, 64'h0000000000000006, 1, "R8 unmapped write");
    op(8'h30, 0, 0, "R8 unmapped read");
    op(8'h1B, 0, 0, "R8 gap above fixed");
    op(8'h02, 64'h6, 1, "R8 gap write");
    op(8'h00, 64'h0, 1, "R8 cap write");
    op(8'h00, 0, 0, "R8 cap unchanged");

    op(8'h13, 64'h0000000000000000, 1, "R9 fixed write same cycle");
    op(8'h13, 0, 0, "R9 fixed next cycle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule